// File: doc/BRIEF.md
# SPI NOR Flash Status and Identification Responder

This block is the command-answering part of a serial NOR flash slave. A byte-level SPI front end delivers each received MOSI byte with a one-cycle strobe while chip select is low. The block tracks the slot number within the transaction and latches the first byte as the opcode. For every slot it registers the byte that the front end shifts out on MISO during the next slot. The memory array, erase and program sequencing, and bit-level serial timing live elsewhere. Two state bits come from that array controller: the busy flag and the continuous-program flag.

The block holds the status register. Its bit positions are fixed: bit 0 busy, bit 1 write-enable latch, bits 5..2 block protection (bit 5 most significant), bit 6 continuous-program, bit 7 status-write lock. The block sets and clears the write-enable latch, and it gates status writes on the latch, the lock bit and a hardware write-protect pin. It returns fixed manufacturer, memory-type and device codes through three identification commands. Each of those commands has its own slot layout.

Opcodes: 0x06 enable writes, 0x04 disable writes, 0x05 read status, 0x01 write status, 0x9F read identification, 0xAB read electronic signature, 0x90 read manufacturer/device pair.

Top module: `spi_nor_regresp`

## Requirements
- R1: After reset, MISO reads 0xFF and the latch, protect and lock bits are all 0, so a status read returns 0x00 while busy_in and cprog_in are low.
- R2: After opcode 0x05, every slot up to chip-select release returns the status byte {lock, cprog_in, protect[3:0], latch, busy_in}.
- R3: Opcode 0x06 sets the write-enable latch (status bit 1), and opcode 0x04 clears it.
- R4: Opcode 0x01 writes only the first following byte, and only when the latch is set and writes are unlocked. Writes are locked when the lock bit is 1 and wp_n is 0. An accepted write updates bit 7 and bits 5..2 only.
- R5: When chip select is released after any transaction that began with 0x01, the latch reads 0, whether or not the write was accepted.
- R6: After 0x9F, slots 1, 2 and 3 return MFR_ID, MEM_TYPE and DEV_ID in that order. Later slots return 0xFF.
- R7: After 0xAB, slots 1 to 3 return 0xFF. Slot 4 and every later slot return DEV_ID.
- R8: After 0x90, slots 1 to 3 return 0xFF. Bit 0 of the byte received in slot 3 selects the order: 0 gives MFR_ID first and 1 gives DEV_ID first. From slot 4 on, the two codes alternate, starting with the selected one.
- R9: MISO is 0xFF while chip select is high, and for every slot after an opcode not listed above.
- R10: Status bits 0 and 6 take the live values of busy_in and cprog_in at the moment each slot's byte is prepared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select from front end, active low |
| byte_vld | input | 1 | One-cycle strobe: a MOSI byte has completed |
| mosi_byte | input | 8 | Byte received in the slot just ended |
| busy_in | input | 1 | Array operation in progress |
| cprog_in | input | 1 | Continuous-program mode active |
| wp_n | input | 1 | Hardware write-protect, active low |
| miso_byte | output | 8 | Byte to shift out in the next slot |

## Verification
The assertions assume that byte_vld lasts a single cycle and is ignored while cs_n is high. They also assume that busy_in, cprog_in and wp_n change only between bytes. The bench drives every byte as a one-cycle strobe with cs_n held low, and it changes the side inputs only at falling clock edges between strobes. Random transactions use a fixed seed and mix latch commands, status writes with random data and a random wp_n, status reads and both identification orders. Each result is compared against a bench model of the status register.

// File: rtl/spi_nor_regresp.sv
module spi_nor_regresp #(
  parameter logic [7:0] MFR_ID   = 8'h5A,
  parameter logic [7:0] MEM_TYPE = 8'h40,
  parameter logic [7:0] DEV_ID   = 8'h16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       byte_vld,
  input  logic [7:0] mosi_byte,
  input  logic       busy_in,
  input  logic       cprog_in,
  input  logic       wp_n,
  output logic [7:0] miso_byte
);
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_RDID = 8'h9F;
  localparam logic [7:0] OP_RES  = 8'hAB;
  localparam logic [7:0] OP_REMS = 8'h90;
  localparam logic [2:0] SLOT_MAX = 3'd7;

  logic [7:0] cmd_q, miso_q, nxt_miso;
  logic [2:0] slot_q;
  logic       wel_q, srwd_q, sel_q, alt_q;
  logic [3:0] bp_q;

  wire        take   = byte_vld & ~cs_n;
  wire [7:0]  op     = (slot_q == 3'd0) ? mosi_byte : cmd_q;
  wire [7:0]  status = {srwd_q, cprog_in, bp_q, wel_q, busy_in};
  wire        locked = srwd_q & ~wp_n;
  wire        wr_ok  = take && slot_q == 3'd1 && cmd_q == OP_WRSR && wel_q && !locked;

  assign miso_byte = miso_q;

  always_comb begin
    nxt_miso = 8'hFF;
    case (op)
      OP_RDSR: nxt_miso = status;
      OP_RDID: begin
        if (slot_q == 3'd0)      nxt_miso = MFR_ID;
        else if (slot_q == 3'd1) nxt_miso = MEM_TYPE;
        else if (slot_q == 3'd2) nxt_miso = DEV_ID;
      end
      OP_RES:  if (slot_q >= 3'd3) nxt_miso = DEV_ID;
      OP_REMS: begin
        if (slot_q == 3'd3)      nxt_miso = mosi_byte[0] ? DEV_ID : MFR_ID;
        else if (slot_q >= 3'd4) nxt_miso = (alt_q ^ sel_q) ? DEV_ID : MFR_ID;
      end
      default: nxt_miso = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= 8'h00;
      slot_q <= 3'd0;
      miso_q <= 8'hFF;
      wel_q  <= 1'b0;
      srwd_q <= 1'b0;
      bp_q   <= 4'h0;
      sel_q  <= 1'b0;
      alt_q  <= 1'b0;
    end else if (cs_n) begin
      if (slot_q != 3'd0 && cmd_q == OP_WRSR) wel_q <= 1'b0;
      cmd_q  <= 8'h00;
      slot_q <= 3'd0;
      miso_q <= 8'hFF;
      alt_q  <= 1'b0;
    end else if (byte_vld) begin
      miso_q <= nxt_miso;
      if (slot_q != SLOT_MAX) slot_q <= slot_q + 3'd1;
      if (slot_q == 3'd0) begin
        cmd_q <= mosi_byte;
        if (mosi_byte == OP_WREN) wel_q <= 1'b1;
        if (mosi_byte == OP_WRDI) wel_q <= 1'b0;
      end
      if (wr_ok) begin
        srwd_q <= mosi_byte[7];
        bp_q   <= mosi_byte[5:2];
      end
      if (cmd_q == OP_REMS && slot_q == 3'd3) begin
        sel_q <= mosi_byte[0];
        alt_q <= 1'b1;
      end else if (cmd_q == OP_REMS && slot_q >= 3'd4) begin
        alt_q <= ~alt_q;
      end
    end
  end
endmodule

// File: rtl/spi_nor_regresp_chk.sv
module spi_nor_regresp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       byte_vld,
  input logic [7:0] mosi_byte,
  input logic       wp_n,
  input logic [7:0] miso_byte,
  input logic [7:0] cmd_q,
  input logic [2:0] slot_q,
  input logic       wel_q,
  input logic       srwd_q,
  input logic [3:0] bp_q
);
  wire take = byte_vld & ~cs_n;

  AST_IDLE_MISO_FF: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> miso_byte == 8'hFF); // R9
  AST_WREN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && slot_q == 3'd0 && mosi_byte == 8'h06) |=> wel_q); // R3
  AST_WRDI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && slot_q == 3'd0 && mosi_byte == 8'h04) |=> !wel_q); // R3
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (srwd_q && !wp_n) |=> $stable({srwd_q, bp_q})); // R4
  AST_NO_STROBE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable({srwd_q, bp_q})); // R4
  AST_WRSR_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && slot_q != 3'd0 && cmd_q == 8'h01) |=> !wel_q); // R5
  AST_RDSR_LATCH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && slot_q != 3'd0 && cmd_q == 8'h05) |=> miso_byte[1] == $past(wel_q)); // R2
endmodule

bind spi_nor_regresp spi_nor_regresp_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_vld(byte_vld),
  .mosi_byte(mosi_byte), .wp_n(wp_n), .miso_byte(miso_byte),
  .cmd_q(cmd_q), .slot_q(slot_q), .wel_q(wel_q), .srwd_q(srwd_q), .bp_q(bp_q)
);

// File: tb/spi_nor_regresp_tb_top.sv
module spi_nor_regresp_tb_top;
  localparam logic [7:0] MFR = 8'h5A, MEM = 8'h40, DEV = 8'h16;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, byte_vld = 1'b0;
  logic busy_in = 1'b0, cprog_in = 1'b0, wp_n = 1'b1;
  logic [7:0] mosi_byte = 8'h00, miso_byte, r;
  int errors = 0, checks = 0;
  logic m_wel = 1'b0, m_srwd = 1'b0;
  logic [3:0] m_bp = 4'h0;

  always #4 clk = ~clk;

  spi_nor_regresp #(.MFR_ID(MFR), .MEM_TYPE(MEM), .DEV_ID(DEV)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_vld(byte_vld), .mosi_byte(mosi_byte),
    .busy_in(busy_in), .cprog_in(cprog_in), .wp_n(wp_n), .miso_byte(miso_byte));

  function automatic logic [7:0] exp_status();
    return {m_srwd, cprog_in, m_bp, m_wel, busy_in};
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, output logic [7:0] res);
    @(negedge clk); mosi_byte = b; byte_vld = 1'b1;
    @(negedge clk); byte_vld = 1'b0; res = miso_byte;
  endtask

  task automatic cs_on();
    @(negedge clk); cs_n = 1'b0;
  endtask

  task automatic cs_off();
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_wrsr(input logic [7:0] d);
    cs_on(); send(8'h01, r); send(d, r); send(~d, r); cs_off();
    if (m_wel && !(m_srwd && !wp_n)) begin m_srwd = d[7]; m_bp = d[5:2]; end
    m_wel = 1'b0;
  endtask

  task automatic do_op(input logic [7:0] op);
    cs_on(); send(op, r); cs_off();
    if (op == 8'h06) m_wel = 1'b1;
    if (op == 8'h04) m_wel = 1'b0;
  endtask

  task automatic rd_status(input string tag, input int n);
    cs_on();
    send(8'h05, r); chk(tag, r, exp_status());
    for (int i = 1; i < n; i++) begin send(8'h00, r); chk(tag, r, exp_status()); end
    cs_off();
  endtask

  task automatic rems(input logic [7:0] sel, input int n);
    cs_on();
    send(8'h90, r); chk("R8 dummy", r, 8'hFF);
    send(8'h00, r); chk("R8 dummy", r, 8'hFF);
    send(8'h00, r); chk("R8 dummy", r, 8'hFF);
    send(sel, r);
    for (int i = 0; i < n; i++) begin
      chk("R8 order", r, ((i % 2 == 1) ^ sel[0]) ? DEV : MFR);
      send(8'h00, r);
    end
    cs_off();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset miso", miso_byte, 8'hFF);
    rd_status("R1 R2 reset status", 4);
    chk("R9 cs high", miso_byte, 8'hFF);

    do_op(8'h06); rd_status("R3 wren", 1);
    do_op(8'h04); rd_status("R3 wrdi", 1);

    do_wrsr(8'hFF); rd_status("R4 write without latch", 1);
    do_op(8'h06); do_wrsr(8'hFF); rd_status("R4 R5 accepted write", 1);
    chk("R4 masked bits", {m_srwd, m_bp}, 5'b11111);

    wp_n = 1'b0;
    do_op(8'h06); do_wrsr(8'h00); rd_status("R4 R5 locked write", 1);
    wp_n = 1'b1;
    do_op(8'h06); do_wrsr(8'h00); rd_status("R4 unlocked write", 1);

    cs_on(); send(8'h06, r); cs_off(); m_wel = 1'b1;
    cs_on(); send(8'h01, r); cs_off(); m_wel = 1'b0;
    rd_status("R5 opcode-only write", 1);

    busy_in = 1'b1; cprog_in = 1'b1;
    cs_on(); send(8'h05, r); chk("R10 live bits", r, exp_status());
    @(negedge clk); busy_in = 1'b0;
    send(8'h00, r); chk("R10 live change", r, exp_status());
    cs_off(); cprog_in = 1'b0;

    cs_on();
    send(8'h9F, r); chk("R6 mfr", r, MFR);
    send(8'h00, r); chk("R6 mem", r, MEM);
    send(8'h00, r); chk("R6 dev", r, DEV);
    send(8'h00, r); chk("R6 tail", r, 8'hFF);
    cs_off();

    cs_on();
    send(8'hAB, r); chk("R7 dummy", r, 8'hFF);
    send(8'h00, r); chk("R7 dummy", r, 8'hFF);
    send(8'h00, r); chk("R7 dummy", r, 8'hFF);
    send(8'h00, r); chk("R7 dev", r, DEV);
    for (int i = 0; i < 5; i++) begin send(8'h00, r); chk("R7 dev repeat", r, DEV); end
    cs_off();

    rems(8'h00, 8);
    rems(8'h01, 8);

    cs_on();
    send(8'h3B, r); chk("R9 unknown", r, 8'hFF);
    send(8'h05, r); chk("R9 unknown", r, 8'hFF);
    cs_off();
    chk("R9 idle", miso_byte, 8'hFF);

    for (int it = 0; it < 400; it++) begin
      int k;
      k = $urandom_range(0, 5);
      @(negedge clk);
      wp_n = $urandom_range(0, 1) != 0;
      busy_in = $urandom_range(0, 1) != 0;
      cprog_in = $urandom_range(0, 1) != 0;
      case (k)
        0: do_op(8'h06);
        1: do_op(8'h04);
        2: begin do_op(8'h06); do_wrsr(8'($urandom)); end
        3: do_wrsr(8'($urandom));
        4: rd_status("R2 random status", $urandom_range(1, 10));
        default: rems({7'd0, 1'($urandom)}, $urandom_range(1, 6));
      endcase
    end
    rd_status("R2 final status", 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule